// File: doc/BRIEF.md
# DAC ramp waveform sequencer

The block drives nine auxiliary DAC channels from a bank of nine channel registers and can play a short waveform out to the first channel. A 64-entry, 10-bit waveform memory is loaded through its own write port. A host then writes single-word commands over a register-write interface (write strobe, 8-bit address, 16-bit data) to sweep a pointer through that memory. The pointer can sweep upward, sweep downward, bounce up and down without end, or be cleared.

A rate register sets how many clock cycles each memory location is held before the pointer moves. When the select bit in channel 0's register is set, channel 0 takes its value from the memory location under the pointer. When that bit is clear, channel 0 takes the static value held in the register. Every channel register also carries an enable bit, which is brought out as an output enable for the analogue stage. A busy output shows that a sweep is in progress.

Top module: `dac_ramp_sequencer`

## Requirements
- R1: After reset, all channel registers and the rate register are zero, every output enable and every channel value is zero, busy is low and the pointer is at location 0.
- R2: A write to address 0x89+k (k = 0..8) loads channel k. Bit 15 drives dacEn[k] and bits 9:0 drive dacOut[10k+9:10k] (for k = 0 only when bit 12 is clear). Writes to any other address leave the channel outputs unchanged.
- R3: While channel 0's bit 12 is set, dacOut[9:0] equals the memory word at the current pointer. While it is clear, dacOut[9:0] equals channel 0's bits 9:0.
- R4: Address 0x84 bits 7:0 set a rate value N. During a sweep the pointer moves once every N+1 cycles, and the interval count restarts from zero on every sweep command.
- R5: Command 0x85 (up) moves the pointer upward one location per step from where it is. After the step taken at location 63, the sweep stops with the pointer left at 63.
- R6: Command 0x86 (down) moves the pointer downward one location per step. After the step taken at location 0, the sweep stops with the pointer left at 0.
- R7: Command 0x87 (cycle) bounces the pointer between 0 and 63 without end. Neither end location is visited twice in a row, so a full up-and-down period is 126 steps.
- R8: Command 0x88 (clear) stops any sweep at once and returns the pointer to 0.
- R9: A running cycle sweep ends on an up, down or clear command, or on a write to address 0x89 with bit 12 clear.
- R10: While channel 0's bit 13 (hold) is set, a running sweep neither counts nor moves its pointer.
- R11: When channel 0's bit 14 (reverse) is set as a command arrives, up behaves as down, down behaves as up, and cycle begins in the descending direction.
- R12: busy is high exactly while a sweep of any kind is in progress.
- R13: A cycle that carries a sweep command, or a cancelling write, takes no pointer step even if the interval count has expired in that cycle.
- R14: A word written to the memory is seen on dacOut[9:0] in the next cycle when the pointer is at that location and bit 12 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register/command write strobe |
| wrAddr | input | 8 | Register or command address |
| wrData | input | 16 | Write data |
| ramWe | input | 1 | Waveform memory write enable |
| ramWaddr | input | 6 | Waveform memory write address |
| ramWdata | input | 10 | Waveform memory write data |
| dacOut | output | 90 | Nine 10-bit channel values, channel k in bits 10k+9:10k |
| dacEn | output | 9 | Per-channel output enable |
| busy | output | 1 | A sweep is in progress |

## Verification
The collision that matters is a host write landing in the very cycle in which the rate counter expires. The write can be a new sweep command, a clear, or a channel 0 write that cancels a cycle. With the rate set to zero every cycle is a step cycle, so each such write collides by construction. The bench issues these writes mid-sweep and checks that the pointer seen on channel 0 stays where it was, with no step, and that the new mode takes over from the next cycle. A randomized phase then mixes commands, rate changes, hold toggles and memory writes, and compares every output against a cycle-level model on every clock.

// File: rtl/wrp_pkg.sv
`timescale 1ns/1ps
package wrp_pkg;

  // Sweep modes of the pointer sequencer
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_UP    = 2'd1,
    M_DOWN  = 2'd2,
    M_CYCLE = 2'd3
  } wrp_mode_e;

  // One-cycle strobes decoded from host writes, consumed by the sequencer
  typedef struct packed {
    logic up;
    logic down;
    logic cycle;
    logic clear;
    logic cancel;
  } wrp_cmd_t;

  // Address map
  localparam logic [7:0] OP_RATE      = 8'h84;
  localparam logic [7:0] OP_UP        = 8'h85;
  localparam logic [7:0] OP_DOWN      = 8'h86;
  localparam logic [7:0] OP_CYCLE     = 8'h87;
  localparam logic [7:0] OP_CLEAR     = 8'h88;
  localparam logic [7:0] OP_CHAN_BASE = 8'h89;

endpackage

// File: rtl/wrp_regs.sv
`timescale 1ns/1ps
module wrp_regs
  import wrp_pkg::*;
#(
  parameter int NCH    = 9,
  parameter int DW     = 10,
  parameter int RATE_W = 8,
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  output wrp_cmd_t          cmd,
  output logic [RATE_W-1:0] rate,
  output logic [NCH*DW-1:0] chanVal,
  output logic [NCH-1:0]    chanEn,
  output logic              useRam,
  output logic              hold,
  output logic              reverse
);

  localparam int EN_BIT   = WORD_W - 1;
  localparam int REV_BIT  = WORD_W - 2;
  localparam int HOLD_BIT = WORD_W - 3;
  localparam int SEL_BIT  = WORD_W - 4;

  localparam logic [ADDR_W-1:0] A_RATE  = ADDR_W'(OP_RATE);
  localparam logic [ADDR_W-1:0] A_UP    = ADDR_W'(OP_UP);
  localparam logic [ADDR_W-1:0] A_DOWN  = ADDR_W'(OP_DOWN);
  localparam logic [ADDR_W-1:0] A_CYCLE = ADDR_W'(OP_CYCLE);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OP_CLEAR);
  localparam logic [ADDR_W-1:0] A_CH0   = ADDR_W'(OP_CHAN_BASE);

  logic [NCH-1:0] chanWr;
  logic [2:0]     ctlQ;      // {reverse, hold, select}
  logic           unusedWr;

  assign unusedWr = ^wrData[SEL_BIT-1:DW];

  // Channel registers: enable bit and static value per channel
  for (genvar k = 0; k < NCH; k++) begin : g_chan
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(OP_CHAN_BASE) + k);
    logic          enQ;
    logic [DW-1:0] valQ;

    assign chanWr[k] = wrEn && (wrAddr == MY_ADDR);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ  <= 1'b0;
        valQ <= '0;
      end else if (chanWr[k]) begin
        enQ  <= wrData[EN_BIT];
        valQ <= wrData[DW-1:0];
      end
    end

    assign chanEn[k]            = enQ;
    assign chanVal[k*DW +: DW]  = valQ;
  end

  // Extra control bits that only channel 0 carries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '0;
    end else if (chanWr[0]) begin
      ctlQ <= {wrData[REV_BIT], wrData[HOLD_BIT], wrData[SEL_BIT]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rate <= '0;
    end else if (wrEn && wrAddr == A_RATE) begin
      rate <= wrData[RATE_W-1:0];
    end
  end

  assign reverse = ctlQ[2];
  assign hold    = ctlQ[1];
  assign useRam  = ctlQ[0];

  // Command strobes
  always_comb begin
    cmd        = '0;
    cmd.up     = wrEn && (wrAddr == A_UP);
    cmd.down   = wrEn && (wrAddr == A_DOWN);
    cmd.cycle  = wrEn && (wrAddr == A_CYCLE);
    cmd.clear  = wrEn && (wrAddr == A_CLEAR);
    cmd.cancel = wrEn && (wrAddr == A_CH0) && !wrData[SEL_BIT];
  end

  // A channel 0 write with select set must leave select set afterwards
  AST_SEL_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_CH0 && wrData[SEL_BIT]) |=> useRam) else $error("select load"); // R3

endmodule

// File: rtl/wrp_seq.sv
`timescale 1ns/1ps
module wrp_seq
  import wrp_pkg::*;
#(
  parameter int AW     = 6,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrp_cmd_t          cmd,
  input  logic [RATE_W-1:0] rate,
  input  logic              hold,
  input  logic              reverse,
  output logic [AW-1:0]     ptr,
  output logic              busy
);

  localparam logic [AW-1:0] TOP    = '1;
  localparam logic [AW-1:0] BOTTOM = '0;

  wrp_mode_e         mode;
  logic              goingDown;
  logic [AW-1:0]     ptrQ;
  logic [RATE_W-1:0] divCnt;
  logic              anyCmd;
  logic              stepNow;

  assign anyCmd  = cmd.up | cmd.down | cmd.cycle | cmd.clear |
                   (cmd.cancel && mode == M_CYCLE);
  assign stepNow = (mode != M_IDLE) && !hold && !anyCmd && (divCnt >= rate);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= M_IDLE;
      goingDown <= 1'b0;
      ptrQ      <= '0;
      divCnt    <= '0;
    end else if (cmd.clear) begin
      mode      <= M_IDLE;
      goingDown <= 1'b0;
      ptrQ      <= '0;
      divCnt    <= '0;
    end else if (cmd.up) begin
      mode   <= reverse ? M_DOWN : M_UP;
      divCnt <= '0;
    end else if (cmd.down) begin
      mode   <= reverse ? M_UP : M_DOWN;
      divCnt <= '0;
    end else if (cmd.cycle) begin
      mode      <= M_CYCLE;
      goingDown <= reverse;
      divCnt    <= '0;
    end else if (cmd.cancel && mode == M_CYCLE) begin
      mode <= M_IDLE;
    end else if (mode != M_IDLE && !hold) begin
      if (divCnt >= rate) begin
        divCnt <= '0;
        unique case (mode)
          M_UP: begin
            if (ptrQ == TOP) mode <= M_IDLE;
            else             ptrQ <= ptrQ + 1'b1;
          end
          M_DOWN: begin
            if (ptrQ == BOTTOM) mode <= M_IDLE;
            else                ptrQ <= ptrQ - 1'b1;
          end
          M_CYCLE: begin
            if (!goingDown) begin
              if (ptrQ == TOP) begin
                goingDown <= 1'b1;
                ptrQ      <= TOP - 1'b1;
              end else begin
                ptrQ <= ptrQ + 1'b1;
              end
            end else begin
              if (ptrQ == BOTTOM) begin
                goingDown <= 1'b0;
                ptrQ      <= BOTTOM + 1'b1;
              end else begin
                ptrQ <= ptrQ - 1'b1;
              end
            end
          end
          default: mode <= M_IDLE;
        endcase
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign ptr  = ptrQ;
  assign busy = (mode != M_IDLE);

  AST_CLEAR_HOME: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (ptrQ == BOTTOM && !busy)) else $error("clear"); // R8
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && mode == M_UP && ptrQ != TOP) |=> (ptrQ == $past(ptrQ) + 1'b1)) else $error("up step"); // R5
  AST_DOWN_END: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && mode == M_DOWN && ptrQ == BOTTOM) |=> (!busy && ptrQ == BOTTOM)) else $error("down end"); // R6
  AST_CYC_TURN: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && mode == M_CYCLE && !goingDown && ptrQ == TOP) |=> (busy && ptrQ == TOP - 1'b1)) else $error("turn"); // R7
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hold && !anyCmd) |=> $stable(ptrQ)) else $error("hold"); // R10
  AST_CMD_NOSTEP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.up || cmd.down || cmd.cycle) |=> ($stable(ptrQ) && busy)) else $error("cmd step"); // R13

endmodule

// File: rtl/wrp_dpath.sv
`timescale 1ns/1ps
module wrp_dpath #(
  parameter int AW = 6,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ramWe,
  input  logic [AW-1:0] ramWaddr,
  input  logic [DW-1:0] ramWdata,
  input  logic [AW-1:0] rdPtr,
  input  logic          useRam,
  input  logic [DW-1:0] staticVal,
  output logic [DW-1:0] ch0Val
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ramWe) mem[ramWaddr] <= ramWdata;
  end

  assign ch0Val = useRam ? mem[rdPtr] : staticVal;

  AST_RAM_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    ((ramWe && ramWaddr == rdPtr) ##1 (useRam && rdPtr == $past(rdPtr))) |-> (ch0Val == $past(ramWdata))) else $error("ram write"); // R14

endmodule

// File: rtl/dac_ramp_sequencer.sv
`timescale 1ns/1ps
module dac_ramp_sequencer
  import wrp_pkg::*;
#(
  parameter int NCH    = 9,
  parameter int DW     = 10,
  parameter int AW     = 6,
  parameter int RATE_W = 8,
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              ramWe,
  input  logic [AW-1:0]     ramWaddr,
  input  logic [DW-1:0]     ramWdata,
  output logic [NCH*DW-1:0] dacOut,
  output logic [NCH-1:0]    dacEn,
  output logic              busy
);

  wrp_cmd_t          cmd;
  logic [RATE_W-1:0] rate;
  logic [NCH*DW-1:0] chanVal;
  logic              useRam;
  logic              hold;
  logic              reverse;
  logic [AW-1:0]     ptr;
  logic [DW-1:0]     ch0Val;

  wrp_regs #(
    .NCH(NCH), .DW(DW), .RATE_W(RATE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmd(cmd), .rate(rate), .chanVal(chanVal), .chanEn(dacEn),
    .useRam(useRam), .hold(hold), .reverse(reverse)
  );

  wrp_seq #(
    .AW(AW), .RATE_W(RATE_W)
  ) u_seq (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rate(rate), .hold(hold),
    .reverse(reverse), .ptr(ptr), .busy(busy)
  );

  wrp_dpath #(
    .AW(AW), .DW(DW)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ramWe(ramWe), .ramWaddr(ramWaddr),
    .ramWdata(ramWdata), .rdPtr(ptr), .useRam(useRam),
    .staticVal(chanVal[DW-1:0]), .ch0Val(ch0Val)
  );

  assign dacOut = {chanVal[NCH*DW-1:DW], ch0Val};

endmodule

// File: tb/dac_ramp_sequencer_bench.sv
`timescale 1ns/1ps
module dac_ramp_sequencer_bench;
  localparam int NCH = 9;
  localparam int DW  = 10;
  localparam int AW  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic ramWe = 1'b0;
  logic [AW-1:0] ramWaddr = '0;
  logic [DW-1:0] ramWdata = '0;
  logic [NCH*DW-1:0] dacOut;
  logic [NCH-1:0] dacEn;
  logic busy;

  always #2.5 clk = ~clk;

  dac_ramp_sequencer u_dac_ramp_sequencer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ramWe(ramWe), .ramWaddr(ramWaddr), .ramWdata(ramWdata),
    .dacOut(dacOut), .dacEn(dacEn), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state
  logic [15:0]   mRegs [NCH];
  logic [7:0]    mRate = '0;
  int            mMode = 0;   // 0 idle, 1 up, 2 down, 3 cycle
  bit            mDown = 1'b0;
  int            mPtr  = 0;
  logic [7:0]    mCnt  = '0;
  logic [DW-1:0] mRam [64];

  function automatic logic [DW-1:0] wave(input int i);
    return DW'((i * 13 + 7) & 10'h3FF);
  endfunction

  function automatic logic [DW-1:0] expCh0();
    return mRegs[0][12] ? mRam[mPtr] : mRegs[0][DW-1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    bit rev, hld, cUp, cDn, cCy, cCl, cCan;
    logic [7:0] oldRate;
    rev = mRegs[0][14];
    hld = mRegs[0][13];
    oldRate = mRate;
    cUp  = wrEn && wrAddr == 8'h85;
    cDn  = wrEn && wrAddr == 8'h86;
    cCy  = wrEn && wrAddr == 8'h87;
    cCl  = wrEn && wrAddr == 8'h88;
    cCan = wrEn && wrAddr == 8'h89 && !wrData[12];
    if (cCl) begin
      mMode = 0; mPtr = 0; mCnt = 0; mDown = 0;
    end else if (cUp) begin
      mMode = rev ? 2 : 1; mCnt = 0;
    end else if (cDn) begin
      mMode = rev ? 1 : 2; mCnt = 0;
    end else if (cCy) begin
      mMode = 3; mDown = rev; mCnt = 0;
    end else if (cCan && mMode == 3) begin
      mMode = 0;
    end else if (mMode != 0 && !hld) begin
      if (mCnt >= oldRate) begin
        mCnt = 0;
        case (mMode)
          1: if (mPtr == 63) mMode = 0; else mPtr++;
          2: if (mPtr == 0) mMode = 0; else mPtr--;
          default: begin
            if (!mDown) begin
              if (mPtr == 63) begin mDown = 1; mPtr = 62; end else mPtr++;
            end else begin
              if (mPtr == 0) begin mDown = 0; mPtr = 1; end else mPtr--;
            end
          end
        endcase
      end else begin
        mCnt = mCnt + 8'd1;
      end
    end
    if (wrEn) begin
      if (wrAddr == 8'h84) mRate = wrData[7:0];
      if (wrAddr >= 8'h89 && wrAddr <= 8'h91) mRegs[wrAddr - 8'h89] = wrData;
    end
    if (ramWe) mRam[ramWaddr] = ramWdata;
  endtask

  task automatic compareAll();
    for (int k = 0; k < NCH; k++) begin
      logic [DW-1:0] ev;
      ev = (k == 0) ? expCh0() : mRegs[k][DW-1:0];
      check(dacEn[k] == mRegs[k][15], "R2 enable", int'(dacEn[k]), int'(mRegs[k][15]));
      check(dacOut[k*DW +: DW] == ev, (k == 0) ? "R3 channel0" : "R2 channel",
            int'(dacOut[k*DW +: DW]), int'(ev));
    end
    check(busy == (mMode != 0), "R12 busy", int'(busy), int'(mMode != 0));
  endtask

  // One clock: inputs already set, model follows the edge, outputs sampled 2 ns later
  task automatic cyc();
    @(posedge clk);
    if (rstN) modelEdge();
    #2;
    compareAll();
    wrEn = 1'b0;
    ramWe = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  function automatic logic [DW-1:0] ch0();
    return dacOut[DW-1:0];
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int n;
    logic [DW-1:0] last, held;
    void'($urandom(32'd24681));
    for (int k = 0; k < NCH; k++) mRegs[k] = '0;
    for (int i = 0; i < 64; i++) mRam[i] = '0;

    idle(3);
    #0 rstN = 1'b1;
    cyc();
    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(dacEn == '0, "R1 enables", int'(dacEn), 0);
    check(dacOut == '0, "R1 values", int'(dacOut[31:0]), 0);

    // Load the waveform
    for (int i = 0; i < 64; i++) begin
      ramWe = 1'b1; ramWaddr = AW'(i); ramWdata = wave(i);
      cyc();
    end
    wr(8'h89, 16'h9000 | 16'h155);
    check(ch0() == wave(0), "R3 ram select", int'(ch0()), int'(wave(0)));
    wr(8'h8C, 16'h8000 | 16'h2B1);
    check(dacOut[3*DW +: DW] == 10'h2B1 && dacEn[3], "R2 channel3", int'(dacOut[3*DW +: DW]), 'h2B1);
    wr(8'h40, 16'hFFFF);
    check(dacOut[3*DW +: DW] == 10'h2B1, "R2 unmapped write", int'(dacOut[3*DW +: DW]), 'h2B1);

    // R14 memory write seen next cycle
    ramWe = 1'b1; ramWaddr = '0; ramWdata = 10'h2AA;
    cyc();
    check(ch0() == 10'h2AA, "R14 ram write", int'(ch0()), 'h2AA);
    ramWe = 1'b1; ramWaddr = '0; ramWdata = wave(0);
    cyc();

    // R5 up sweep at rate 0
    wr(8'h85, 16'h0);
    n = 0; last = '0;
    while (busy && n < 1000) begin n++; last = ch0(); cyc(); end
    check(n == 64, "R5 up length", n, 64);
    check(last == wave(63), "R5 up end", int'(last), int'(wave(63)));

    // R4 / R6 down sweep at rate 2
    wr(8'h84, 16'h0002);
    wr(8'h86, 16'h0);
    n = 0;
    while (busy && n < 1000) begin n++; cyc(); end
    check(n == 192, "R4 interval", n, 192);
    check(ch0() == wave(0), "R6 down end", int'(ch0()), int'(wave(0)));

    // R7 cycle at rate 0
    wr(8'h84, 16'h0000);
    wr(8'h87, 16'h0);
    idle(63);
    check(ch0() == wave(63) && busy, "R7 top", int'(ch0()), int'(wave(63)));
    idle(63);
    check(ch0() == wave(0) && busy, "R7 period", int'(ch0()), int'(wave(0)));
    cyc();
    check(ch0() == wave(1), "R7 bounce", int'(ch0()), int'(wave(1)));

    // R13 command in a step cycle takes no step
    wr(8'h85, 16'h0);
    check(ch0() == wave(1), "R13 no step", int'(ch0()), int'(wave(1)));
    cyc();
    check(ch0() == wave(2), "R13 resume", int'(ch0()), int'(wave(2)));

    // R10 hold
    wr(8'h89, 16'hB000);
    held = ch0();
    idle(10);
    check(ch0() == held && busy, "R10 hold", int'(ch0()), int'(held));
    wr(8'h89, 16'h9000);
    idle(2);

    // R8 clear
    wr(8'h88, 16'h0);
    check(!busy && ch0() == wave(0), "R8 clear", int'(ch0()), int'(wave(0)));

    // R9 cancel through select bit
    wr(8'h87, 16'h0);
    idle(5);
    wr(8'h89, 16'h8000);
    check(busy == 1'b0, "R9 cancel", int'(busy), 0);
    wr(8'h89, 16'h9000);
    wr(8'h87, 16'h0);
    idle(3);
    wr(8'h88, 16'h0);
    check(busy == 1'b0, "R9 clear ends cycle", int'(busy), 0);

    // R11 reverse
    wr(8'h85, 16'h0);
    idle(9);
    wr(8'h89, 16'hD000);
    wr(8'h85, 16'h0);
    idle(3);
    check(ch0() == wave(7), "R11 reverse", int'(ch0()), int'(wave(7)));
    wr(8'h89, 16'h9000);
    wr(8'h88, 16'h0);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 20);
      case (r)
        0: begin wrEn = 1; wrAddr = 8'h84; wrData = 16'($urandom % 4); end
        1: begin wrEn = 1; wrAddr = 8'h85; wrData = 16'($urandom); end
        2: begin wrEn = 1; wrAddr = 8'h86; wrData = 16'($urandom); end
        3: begin wrEn = 1; wrAddr = 8'h87; wrData = 16'($urandom); end
        4: if ($urandom % 3 == 0) begin wrEn = 1; wrAddr = 8'h88; wrData = 16'($urandom); end
        5: begin
          wrEn = 1; wrAddr = 8'h89; wrData = 16'($urandom);
          if ($urandom % 4 != 0) wrData[13] = 1'b0;
          if ($urandom % 4 != 0) wrData[12] = 1'b1;
        end
        6: begin wrEn = 1; wrAddr = 8'(8'h8A + $urandom % 8); wrData = 16'($urandom); end
        7, 8: begin ramWe = 1; ramWaddr = AW'($urandom); ramWdata = DW'($urandom); end
        9: begin wrEn = 1; wrAddr = 8'($urandom % 8'h84); wrData = 16'($urandom); end
        default: ;
      endcase
      cyc();
    end

    finishRun();
  end

endmodule